// File: doc/BRIEF.md
# Perspective Vertex Projector

This block turns one model-space vertex into a screen position and a depth value for a fixed-point 3D geometry engine. It multiplies the vertex by a signed 3x3 rotation matrix in 4.12 format and adds a translation vector. It clamps the depth, then divides a projection distance by that depth. The quotient scales the first two rotated components into screen X and Y around a screen centre. The same quotient drives a linear depth-cue term.

All intermediate results are saturated or clamped at fixed points, and each saturation leaves a mark in a 32-bit status word. Screen positions go into a three-deep position history and depths into a four-deep depth history. The oldest entry drops out on each new result.

The caller pulses `start` while the unit is idle. The inputs are captured on that edge. `busy` stays high while a bit-serial divider runs. Every result and the status word then change together in the one cycle in which `done` is high.

Top module: `persp_xform_unit`

## Requirements
- R1: Each of MAC1..MAC3 is (sum over k of row[i][k]*vertex[k] + translation[i]*4096) arithmetically shifted right by 12, then saturated to signed 32 bits. In the status word, a positive saturation sets bit 30, 29 or 28 and a negative saturation sets bit 27, 26 or 25, for rows 1, 2 and 3 in that order.
- R2: IR1..IR3 are MAC1..MAC3 saturated to -32768..32767. Saturation sets status bit 24, 23 or 22 in that order.
- R3: The new depth is MAC3 clamped to 0..65535, and a clamp sets status bit 18. On each result the depth history shifts: sz0<=sz1, sz1<=sz2, sz2<=sz3, and sz3 takes the new depth.
- R4: When projection distance H (unsigned) halved is below the new depth, the quotient is (H*65536)/depth. Otherwise the quotient is H*65536, because the divisor is forced to 1.
- R5: A quotient above 0x1FFFF is replaced by 0x1FFFF and sets status bit 17.
- R6: Screen X is (offset X + IR1*quotient) saturated to signed 32 bits, arithmetically shifted right by 16 and clamped to -1024..1023. Screen Y is formed the same way from offset Y and IR2. The X clamp sets status bit 14 and the Y clamp sets bit 13. The pair {Y[15:0], X[15:0]} enters the position history: sxy0<=sxy1, sxy1<=sxy2, and sxy2 takes the new pair.
- R7: MAC0 is (DQB + DQA*quotient) saturated to signed 32 bits. Positive saturation sets status bit 16 and negative saturation sets bit 15.
- R8: IR0 is MAC0 arithmetically shifted right by 12 and clamped to 0..4096. A clamp sets status bit 12.
- R9: `start` is honoured only while idle, and the inputs are captured on that edge. `done` is a one-cycle pulse that rises on the 33rd rising edge after the capturing edge. `busy` is low in that cycle. A `start` while busy is ignored.
- R10: Reset clears every output to zero.
- R11: Status bit 31 is the OR of bits 30..23 and 18..13. Bits 22 and 12 do not feed it. The status word reads zero from the capturing edge until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured when idle |
| rot_flat | input | 144 | Matrix; row i at bits [48i+47:48i], column k of a row at [16k+15:16k], signed |
| trans_flat | input | 96 | Translation; component i at [32i+31:32i], signed |
| vtx_flat | input | 48 | Vertex X [15:0], Y [31:16], Z [47:32], signed |
| proj_h | input | 16 | Projection distance, unsigned |
| ofs_x | input | 32 | Screen X offset, signed, 16 fraction bits |
| ofs_y | input | 32 | Screen Y offset, signed, 16 fraction bits |
| dq_a | input | 16 | Depth-cue slope, signed |
| dq_b | input | 32 | Depth-cue base, signed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mac0 | output | 32 | Depth-cue accumulator |
| mac1 | output | 32 | Row 1 accumulator |
| mac2 | output | 32 | Row 2 accumulator |
| mac3 | output | 32 | Row 3 accumulator |
| ir0 | output | 16 | Clamped depth-cue factor |
| ir1 | output | 16 | Saturated row 1 |
| ir2 | output | 16 | Saturated row 2 |
| ir3 | output | 16 | Saturated row 3 |
| sz0 | output | 16 | Oldest depth |
| sz1 | output | 16 | Depth history |
| sz2 | output | 16 | Depth history |
| sz3 | output | 16 | Newest depth |
| sxy0 | output | 32 | Oldest screen pair {Y,X} |
| sxy1 | output | 32 | Screen pair history |
| sxy2 | output | 32 | Newest screen pair |
| flags | output | 32 | Saturation status word |

## Verification
No result is visible before `done`, which rises on the 33rd rising edge after the capturing edge. The bench counts falling edges from the one after the start edge. It requires `done` on exactly the 34th of them, and samples every output only at that falling edge. The history checks compare against the values read from the ports at the previous completion. The ignored-start test changes the vertex partway through an operation. It then checks that the results still follow the captured inputs and that no second `done` follows.

// File: rtl/persp_pkg.sv
package persp_pkg;

    localparam int FB_SUM  = 31;
    localparam int FB_MACP = 30;
    localparam int FB_MACN = 27;
    localparam int FB_IR   = 24;
    localparam int FB_Z    = 18;
    localparam int FB_QLIM = 17;
    localparam int FB_M0P  = 16;
    localparam int FB_M0N  = 15;
    localparam int FB_SX   = 14;
    localparam int FB_SY   = 13;
    localparam int FB_IR0  = 12;

    typedef enum logic {ST_IDLE, ST_DIV} ctl_state_e;

    typedef struct packed {
        logic signed [31:0] val;
        logic               pos;
        logic               neg;
    } sat32_t;

    typedef struct packed {
        logic [15:0] val;
        logic        hit;
    } clip_t;

    function automatic sat32_t sat32(input logic signed [63:0] x);
        sat32_t r;
        r.pos = x > 64'sh7FFF_FFFF;
        r.neg = x < -64'sh8000_0000;
        if (r.pos)      r.val = 32'sh7FFF_FFFF;
        else if (r.neg) r.val = 32'sh8000_0000;
        else            r.val = $signed(x[31:0]);
        return r;
    endfunction

    function automatic clip_t clamp16(input logic signed [31:0] x, input int lo, input int hi);
        clip_t r;
        r.hit = 1'b1;
        if (x < lo)      r.val = lo[15:0];
        else if (x > hi) r.val = hi[15:0];
        else begin
            r.val = x[15:0];
            r.hit = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/persp_row.sv
module persp_row
    import persp_pkg::*;
#(
    parameter int CW   = 16,
    parameter int TW   = 32,
    parameter int FRAC = 12
) (
    input  logic [3*CW-1:0]     row,
    input  logic [3*CW-1:0]     vtx,
    input  logic signed [TW-1:0] trans,
    output sat32_t              mac
);
    localparam int AW = 64;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] shifted;

    always_comb begin
        acc = AW'(trans) <<< FRAC;
        for (int k = 0; k < 3; k++) begin
            acc = acc + AW'($signed(row[k*CW +: CW])) * AW'($signed(vtx[k*CW +: CW]));
        end
        shifted = acc >>> FRAC;
        mac = sat32(shifted);
    end
endmodule

// File: rtl/persp_seqdiv.sv
module persp_seqdiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic [W-1:0] quotient
);
    localparam int CNTW = $clog2(W + 1);

    logic [CNTW-1:0] cnt;
    logic [W:0]      rem;
    logic [W:0]      trial;
    logic [W-1:0]    dvs;

    assign trial = {rem[W-1:0], quotient[W-1]};
    assign busy  = cnt != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            rem      <= '0;
            dvs      <= '0;
            quotient <= '0;
        end else if (load) begin
            cnt      <= CNTW'(W);
            rem      <= '0;
            dvs      <= divisor;
            quotient <= dividend;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (trial >= {1'b0, dvs}) begin
                rem      <= trial - {1'b0, dvs};
                quotient <= {quotient[W-2:0], 1'b1};
            end else begin
                rem      <= trial;
                quotient <= {quotient[W-2:0], 1'b0};
            end
        end
    end

    assert_load_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);
    assert_divisor_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> divisor != '0);
endmodule

// File: rtl/persp_project.sv
module persp_project
    import persp_pkg::*;
#(
    parameter int QW = 17
) (
    input  logic [QW-1:0]      q,
    input  logic signed [15:0] ir_x,
    input  logic signed [15:0] ir_y,
    input  logic signed [31:0] ofx,
    input  logic signed [31:0] ofy,
    input  logic signed [15:0] dqa,
    input  logic signed [31:0] dqb,
    output logic [15:0]        sx,
    output logic [15:0]        sy,
    output logic [31:0]        mac0,
    output logic [15:0]        ir0,
    output logic [31:0]        pflags
);
    localparam int SCR_LO = -1024;
    localparam int SCR_HI = 1023;
    localparam int IR0_HI = 4096;

    logic signed [63:0] qs;
    sat32_t             s_ax  [2];
    clip_t              c_ax  [2];
    sat32_t             s_m0;
    clip_t              c_ir0;

    always_comb begin
        qs      = 64'($signed({1'b0, q}));
        s_ax[0] = sat32(64'(ofx) + 64'(ir_x) * qs);
        s_ax[1] = sat32(64'(ofy) + 64'(ir_y) * qs);
        for (int a = 0; a < 2; a++) begin
            c_ax[a] = clamp16(s_ax[a].val >>> 16, SCR_LO, SCR_HI);
        end
        s_m0  = sat32(64'(dqb) + 64'(dqa) * qs);
        c_ir0 = clamp16(s_m0.val >>> 12, 0, IR0_HI);

        sx   = c_ax[0].val;
        sy   = c_ax[1].val;
        mac0 = s_m0.val;
        ir0  = c_ir0.val;

        pflags          = '0;
        pflags[FB_SX]   = c_ax[0].hit;
        pflags[FB_SY]   = c_ax[1].hit;
        pflags[FB_M0P]  = s_m0.pos;
        pflags[FB_M0N]  = s_m0.neg;
        pflags[FB_IR0]  = c_ir0.hit;
        pflags[FB_SUM]  = c_ax[0].hit | c_ax[1].hit | s_m0.pos | s_m0.neg;
    end
endmodule

// File: rtl/persp_xform_unit.sv
module persp_xform_unit
    import persp_pkg::*;
#(
    parameter int CW   = 16,
    parameter int TW   = 32,
    parameter int DW   = 32,
    parameter int QW   = 17,
    parameter int FRAC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [9*CW-1:0]   rot_flat,
    input  logic [3*TW-1:0]   trans_flat,
    input  logic [3*CW-1:0]   vtx_flat,
    input  logic [15:0]       proj_h,
    input  logic [31:0]       ofs_x,
    input  logic [31:0]       ofs_y,
    input  logic [15:0]       dq_a,
    input  logic [31:0]       dq_b,
    output logic              busy,
    output logic              done,
    output logic [31:0]       mac0,
    output logic [31:0]       mac1,
    output logic [31:0]       mac2,
    output logic [31:0]       mac3,
    output logic [15:0]       ir0,
    output logic [15:0]       ir1,
    output logic [15:0]       ir2,
    output logic [15:0]       ir3,
    output logic [15:0]       sz0,
    output logic [15:0]       sz1,
    output logic [15:0]       sz2,
    output logic [15:0]       sz3,
    output logic [31:0]       sxy0,
    output logic [31:0]       sxy1,
    output logic [31:0]       sxy2,
    output logic [31:0]       flags
);
    localparam int RW = 3 * CW;

    ctl_state_e state;
    sat32_t     row_mac [3];
    clip_t      row_ir  [3];
    clip_t      z_clip;
    logic [31:0] cap_flags;
    logic [DW-1:0] div_dvs;
    logic [DW-1:0] div_q;
    logic          div_busy;
    logic          div_load;
    logic          q_over;
    logic [QW-1:0] q_lim;

    logic [31:0] st_mac [3];
    logic [15:0] st_ir  [3];
    logic [15:0] st_z;
    logic [31:0] st_flags;
    logic [31:0] st_ofx, st_ofy, st_dqb;
    logic [15:0] st_dqa;

    logic [31:0] o_mac [4];
    logic [15:0] o_ir  [4];
    logic [15:0] o_sz  [4];
    logic [31:0] o_sxy [3];

    logic [15:0] pj_sx, pj_sy, pj_ir0;
    logic [31:0] pj_mac0, pj_flags;

    for (genvar gi = 0; gi < 3; gi++) begin : g_row
        persp_row #(.CW(CW), .TW(TW), .FRAC(FRAC)) u_row (
            .row   (rot_flat[gi*RW +: RW]),
            .vtx   (vtx_flat),
            .trans ($signed(trans_flat[gi*TW +: TW])),
            .mac   (row_mac[gi])
        );
        assign row_ir[gi] = clamp16(row_mac[gi].val, -32768, 32767);
    end

    assign z_clip   = clamp16(row_mac[2].val, 0, 65535);
    assign div_load = (state == ST_IDLE) && start;
    assign div_dvs  = ({1'b0, proj_h[15:1]} < z_clip.val) ? DW'(z_clip.val) : DW'(1);

    always_comb begin
        cap_flags = '0;
        for (int k = 0; k < 3; k++) begin
            cap_flags[FB_MACP-k] = row_mac[k].pos;
            cap_flags[FB_MACN-k] = row_mac[k].neg;
            cap_flags[FB_IR-k]   = row_ir[k].hit;
        end
        cap_flags[FB_Z]   = z_clip.hit;
        cap_flags[FB_SUM] = (|cap_flags[FB_MACP:FB_IR-1]) | z_clip.hit;
    end

    persp_seqdiv #(.W(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .dividend ({proj_h, 16'h0000}),
        .divisor  (div_dvs),
        .busy     (div_busy),
        .quotient (div_q)
    );

    assign q_over = |div_q[DW-1:QW];
    assign q_lim  = q_over ? '1 : div_q[QW-1:0];

    persp_project #(.QW(QW)) u_proj (
        .q      (q_lim),
        .ir_x   ($signed(st_ir[0])),
        .ir_y   ($signed(st_ir[1])),
        .ofx    ($signed(st_ofx)),
        .ofy    ($signed(st_ofy)),
        .dqa    ($signed(st_dqa)),
        .dqb    ($signed(st_dqb)),
        .sx     (pj_sx),
        .sy     (pj_sy),
        .mac0   (pj_mac0),
        .ir0    (pj_ir0),
        .pflags (pj_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            flags    <= '0;
            st_z     <= '0;
            st_flags <= '0;
            st_ofx   <= '0;
            st_ofy   <= '0;
            st_dqa   <= '0;
            st_dqb   <= '0;
            for (int k = 0; k < 3; k++) begin
                st_mac[k] <= '0;
                st_ir[k]  <= '0;
                o_sxy[k]  <= '0;
            end
            for (int k = 0; k < 4; k++) begin
                o_mac[k] <= '0;
                o_ir[k]  <= '0;
                o_sz[k]  <= '0;
            end
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    for (int k = 0; k < 3; k++) begin
                        st_mac[k] <= row_mac[k].val;
                        st_ir[k]  <= row_ir[k].val;
                    end
                    st_z     <= z_clip.val;
                    st_flags <= cap_flags;
                    st_ofx   <= ofs_x;
                    st_ofy   <= ofs_y;
                    st_dqa   <= dq_a;
                    st_dqb   <= dq_b;
                    flags    <= '0;
                    state    <= ST_DIV;
                end
                ST_DIV: if (!div_busy) begin
                    for (int k = 0; k < 3; k++) begin
                        o_mac[k+1] <= st_mac[k];
                        o_ir[k+1]  <= st_ir[k];
                        o_sz[k]    <= o_sz[k+1];
                    end
                    o_mac[0] <= pj_mac0;
                    o_ir[0]  <= pj_ir0;
                    o_sz[3]  <= st_z;
                    o_sxy[0] <= o_sxy[1];
                    o_sxy[1] <= o_sxy[2];
                    o_sxy[2] <= {pj_sy, pj_sx};
                    flags    <= st_flags | pj_flags
                              | (q_over ? ((32'd1 << FB_QLIM) | (32'd1 << FB_SUM)) : 32'd0);
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_DIV);
    assign mac0 = o_mac[0];
    assign mac1 = o_mac[1];
    assign mac2 = o_mac[2];
    assign mac3 = o_mac[3];
    assign ir0  = o_ir[0];
    assign ir1  = o_ir[1];
    assign ir2  = o_ir[2];
    assign ir3  = o_ir[3];
    assign sz0  = o_sz[0];
    assign sz1  = o_sz[1];
    assign sz2  = o_sz[2];
    assign sz3  = o_sz[3];
    assign sxy0 = o_sxy[0];
    assign sxy1 = o_sxy[1];
    assign sxy2 = o_sxy[2];

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_flags_clear_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> flags == '0);
    assert_zfifo_shift_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (sz0 == $past(sz1)) && (sz1 == $past(sz2)) && (sz2 == $past(sz3)));
    assert_ir0_range_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($signed(ir0) >= 0) && ($signed(ir0) <= 16'sh1000));
    assert_ir3_extreme_R2: assert property (@(posedge clk) disable iff (rst)
        (done && flags[22]) |-> (ir3 == 16'h7FFF || ir3 == 16'h8000));
    assert_summary_screen_R11: assert property (@(posedge clk) disable iff (rst)
        (done && (flags[14] || flags[13] || flags[17])) |-> flags[31]);
    assert_hist_static_R3: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(sz3) && $stable(sxy2));
endmodule

// File: tb/persp_xform_unit_bench.sv
module persp_xform_unit_bench;

    typedef struct packed {
        int diag; int off;
        int tx; int ty; int tz;
        int vx; int vy; int vz;
        int h; int ofx; int ofy; int dqa; int dqb;
    } vec_t;

    typedef struct {
        longint mac [4];
        longint ir  [4];
        longint z;
        longint sx;
        longint sy;
        longint fl;
    } exp_t;

    localparam int NV = 6;
    localparam int LAT = 34;
    localparam vec_t TABLE [NV] = '{
        '{4096, 0, 0, 0, 0, 100, 200, 1000, 1000, 0, 0, 0, 0},
        '{4096, 0, 0, 0, 0, 100, 200, -5, 1000, 0, 0, 0, 0},
        '{4096, 0, 0, 0, 0, 2000, -3000, 1000, 1000, 0, 0, 0, 0},
        '{32767, 32767, 32'h7FFF_FFFF, 32'h8000_0000, 5, 32767, -32768, 32767,
          32768, 32'h0100_0000, -5000, -32768, 32'h7FFF_0000},
        '{-4096, 1024, 1000, -1000, 50000, 300, -400, 500, 400,
          32'h0140_0000, 32'h00F0_0000, -100, 32'h0100_0000},
        '{8192, 0, 0, 0, 70000, 32767, -32768, 0, 65535, 0, 0, 4096, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [143:0] rot_flat = '0;
    logic [95:0]  trans_flat = '0;
    logic [47:0]  vtx_flat = '0;
    logic [15:0]  proj_h = '0;
    logic [31:0]  ofs_x = '0, ofs_y = '0, dq_b = '0;
    logic [15:0]  dq_a = '0;
    logic busy, done;
    logic [31:0] mac0, mac1, mac2, mac3, sxy0, sxy1, sxy2, flags;
    logic [15:0] ir0, ir1, ir2, ir3, sz0, sz1, sz2, sz3;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    persp_xform_unit u_persp_xform_unit (
        .clk(clk), .rst(rst), .start(start), .rot_flat(rot_flat), .trans_flat(trans_flat),
        .vtx_flat(vtx_flat), .proj_h(proj_h), .ofs_x(ofs_x), .ofs_y(ofs_y), .dq_a(dq_a),
        .dq_b(dq_b), .busy(busy), .done(done), .mac0(mac0), .mac1(mac1), .mac2(mac2),
        .mac3(mac3), .ir0(ir0), .ir1(ir1), .ir2(ir2), .ir3(ir3), .sz0(sz0), .sz1(sz1),
        .sz2(sz2), .sz3(sz3), .sxy0(sxy0), .sxy1(sxy1), .sxy2(sxy2), .flags(flags)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint lim(input longint x, input longint lo, input longint hi);
        return (x < lo) ? lo : ((x > hi) ? hi : x);
    endfunction

    function automatic exp_t model(input vec_t t);
        exp_t e;
        longint vv [3];
        longint tt [3];
        longint acc, zc, q, s, m0;
        longint f;
        f = 0;
        vv = '{longint'(t.vx), longint'(t.vy), longint'(t.vz)};
        tt = '{longint'(t.tx), longint'(t.ty), longint'(t.tz)};
        for (int i = 0; i < 3; i++) begin
            acc = tt[i] * 4096;
            for (int j = 0; j < 3; j++)
                acc += ((i == j) ? longint'(t.diag) : longint'(t.off)) * vv[j];
            acc = acc >>> 12;
            if (acc > 64'sd2147483647) f |= 64'd1 << (30 - i);
            if (acc < -64'sd2147483648) f |= 64'd1 << (27 - i);
            e.mac[i+1] = lim(acc, -64'sd2147483648, 64'sd2147483647);
            if (e.mac[i+1] != lim(e.mac[i+1], -32768, 32767)) f |= 64'd1 << (24 - i);
            e.ir[i+1] = lim(e.mac[i+1], -32768, 32767);
        end
        zc = lim(e.mac[3], 0, 65535);
        if (zc != e.mac[3]) f |= 64'd1 << 18;
        e.z = zc;
        if ((longint'(t.h) / 2) < zc) q = (longint'(t.h) * 65536) / zc;
        else q = longint'(t.h) * 65536;
        if (q > 131071) begin q = 131071; f |= 64'd1 << 17; end
        s = lim(longint'(t.ofx) + e.ir[1] * q, -64'sd2147483648, 64'sd2147483647) >>> 16;
        if (s != lim(s, -1024, 1023)) f |= 64'd1 << 14;
        e.sx = lim(s, -1024, 1023);
        s = lim(longint'(t.ofy) + e.ir[2] * q, -64'sd2147483648, 64'sd2147483647) >>> 16;
        if (s != lim(s, -1024, 1023)) f |= 64'd1 << 13;
        e.sy = lim(s, -1024, 1023);
        m0 = longint'(t.dqb) + longint'(t.dqa) * q;
        if (m0 > 64'sd2147483647) f |= 64'd1 << 16;
        if (m0 < -64'sd2147483648) f |= 64'd1 << 15;
        e.mac[0] = lim(m0, -64'sd2147483648, 64'sd2147483647);
        s = e.mac[0] >>> 12;
        if (s != lim(s, 0, 4096)) f |= 64'd1 << 12;
        e.ir[0] = lim(s, 0, 4096);
        if ((f & 64'h7F87_E000) != 0) f |= 64'd1 << 31;
        e.fl = f;
        return e;
    endfunction

    task automatic drive(input vec_t t);
        for (int i = 0; i < 3; i++)
            for (int k = 0; k < 3; k++)
                rot_flat[i*48 + k*16 +: 16] = (i == k) ? t.diag[15:0] : t.off[15:0];
        trans_flat = {t.tz, t.ty, t.tx};
        vtx_flat   = {t.vz[15:0], t.vy[15:0], t.vx[15:0]};
        proj_h     = t.h[15:0];
        ofs_x      = t.ofx;
        ofs_y      = t.ofy;
        dq_a       = t.dqa[15:0];
        dq_b       = t.dqb;
    endtask

    task automatic check_result(input exp_t e, input longint p_sz3, input longint p_sxy2);
        chk("R1", "mac1", longint'($signed(mac1)), e.mac[1]);
        chk("R1", "mac2", longint'($signed(mac2)), e.mac[2]);
        chk("R1", "mac3", longint'($signed(mac3)), e.mac[3]);
        chk("R2", "ir1", longint'($signed(ir1)), e.ir[1]);
        chk("R2", "ir2", longint'($signed(ir2)), e.ir[2]);
        chk("R2", "ir3", longint'($signed(ir3)), e.ir[3]);
        chk("R3", "sz3", longint'(sz3), e.z);
        chk("R3", "sz2 shift", longint'(sz2), p_sz3);
        chk("R6", "sxy2 x", longint'($signed(sxy2[15:0])), e.sx);
        chk("R6", "sxy2 y", longint'($signed(sxy2[31:16])), e.sy);
        chk("R6", "sxy1 shift", longint'(sxy1), p_sxy2);
        chk("R7", "mac0", longint'($signed(mac0)), e.mac[0]);
        chk("R8", "ir0", longint'($signed(ir0)), e.ir[0]);
        chk("R11", "flags", longint'(flags), e.fl);
    endtask

    task automatic run_op(input vec_t t, input bit poke, output int lat);
        @(negedge clk);
        drive(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (poke && lat == 6) begin
                chk("R11", "flags zero while busy", longint'(flags), 0);
                vtx_flat = 48'h0001_0002_0003;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        longint p_sz3, p_sxy2;
        exp_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10", "busy", longint'(busy), 0);
        chk("R10", "done", longint'(done), 0);
        chk("R10", "flags", longint'(flags), 0);
        chk("R10", "mac1", longint'(mac1), 0);
        chk("R10", "sz3", longint'(sz3), 0);
        chk("R10", "sxy2", longint'(sxy2), 0);

        for (int i = 0; i < NV; i++) begin
            p_sz3  = longint'(sz3);
            p_sxy2 = longint'(sxy2);
            e = model(TABLE[i]);
            run_op(TABLE[i], 1'b0, lat);
            chk("R9", "latency", longint'(lat), LAT);
            chk("R9", "busy low at done", longint'(busy), 0);
            check_result(e, p_sz3, p_sxy2);
            if (i == 0) begin
                chk("R4", "hand sxy2", longint'(sxy2), 64'h00C8_0064);
                chk("R4", "hand flags", longint'(flags), 0);
            end
            if (i == 1) begin
                chk("R5", "hand flags", longint'(flags), 64'h8006_0000);
                chk("R5", "hand sxy2", longint'(sxy2), {32'd0, 16'd399, 16'd199});
            end
            @(negedge clk);
            chk("R9", "done one cycle", longint'(done), 0);
        end

        // R9: start while busy is ignored; captured inputs are used
        p_sz3  = longint'(sz3);
        p_sxy2 = longint'(sxy2);
        e = model(TABLE[4]);
        run_op(TABLE[4], 1'b1, lat);
        chk("R9", "latency with ignored start", longint'(lat), LAT);
        check_result(e, p_sz3, p_sxy2);
        @(negedge clk);
        chk("R9", "no second op busy", longint'(busy), 0);
        repeat (40) begin
            @(negedge clk);
            if (done) chk("R9", "spurious done", 1, 0);
        end
        chk("R9", "state idle after ignored start", longint'(busy), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule